// File: doc/BRIEF.md
# Bit-Pattern Match Interrupt Port

An input port of parameterised width (eight bits by default) that watches its pins for a programmable pattern. Every pin goes through a two-flop synchroniser and an optional per-bit inversion. Three per-bit configuration registers then pick its condition. A select bit includes or excludes the bit. A kind bit chooses edge or level. A sense bit chooses rising/high or falling/low. The qualified bits are then combined across the port in hardware: in any-bit mode one bit meeting its condition is enough, and in all-bits mode every selected bit must meet its condition in the same sample.

A match sets a sticky pending flag when the interrupt enable and the port enable are both on. Software clears that flag with a command. An acknowledge input marks the interrupt as under service, but only while the enable and pending flags are both set. The interrupt line is driven while enable and pending are set and the interrupt is not yet under service. The host reaches the block through a plain register port: writes take effect at the clock edge, and read data is returned one cycle after the read strobe with `rd_valid`.

Top module: `pattern_irq_port`

## Requirements
- R1: After reset every configuration register reads 0, the status register reads 0 and `irq_o` is 0. The address map is: 0 pins (read only), 1 select, 2 kind, 3 sense, 4 invert, 5 mode, 6 command/status. Address 5 holds the match mode in bits [1:0] (00 off, 01 any-bit, 10 all-bits, 11 off) and the port enable in bit 4.
- R2: A bit whose select bit is 0 never causes a match, whatever it does.
- R3: With kind=1 the bit matches on an edge: sense=1 means a rising edge and sense=0 means a falling edge. An edge match sets pending once per edge.
- R4: With kind=0 the bit matches on a level: sense=1 means high and sense=0 means low.
- R5: In any-bit mode (01), one selected bit meeting its condition is a match.
- R6: In all-bits mode (10), a match needs every selected bit to meet its condition in the same sample. If more than one selected bit has kind=1, the pattern never matches.
- R7: The invert register flips the chosen pin bits before matching, and address 0 reads the synchronised pins after inversion.
- R8: Pending is set only while the interrupt enable is 1, the port enable is 1 and the mode is any-bit or all-bits.
- R9: Status reads {IUS, IE, IP, 0, user[3:0]} in bits 7..0. A write to address 6 runs the command in bits [6:4] and always stores bits [3:0] into user. The commands are: 001 clears IP and IUS, 010 sets IE, 011 clears IE, and any other code does nothing.
- R10: A pulse on `ack_i` sets IUS only while IE and IP are both 1. `irq_o` equals IE and IP and not IUS.
- R11: While a level condition keeps holding, a clear-pending command leaves IP set, because the condition sets it again in the same cycle.
- R12: IP and `irq_o` rise on the third rising clock edge after a qualifying pin change: two synchroniser stages, then the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | W | Asynchronous input pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pending flag shows directly on `irq_o` and in status bit 5, on the third clock after the pin change that should (or should not) have caused it. The bench therefore samples the interrupt cycle by cycle for latency and reads status after a short settle for every mode. Bad edge memory shows up as a second pending after a clear with the pins static. A broken edge-count guard in all-bits mode shows up as a pending flag where none may appear. A wrong acknowledge qualification shows up as IUS in status bit 7 and as a dropped `irq_o` at the next sample.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ANY  = 2'b01,
    MODE_ALL  = 2'b10,
    MODE_OFF2 = 2'b11
  } match_mode_e;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'b000,
    CMD_CLR_PND = 3'b001,
    CMD_SET_IE  = 3'b010,
    CMD_CLR_IE  = 3'b011
  } cmd_e;

  localparam logic [2:0] A_PINS  = 3'd0;
  localparam logic [2:0] A_SEL   = 3'd1;
  localparam logic [2:0] A_KIND  = 3'd2;
  localparam logic [2:0] A_SENSE = 3'd3;
  localparam logic [2:0] A_INV   = 3'd4;
  localparam logic [2:0] A_MODE  = 3'd5;
  localparam logic [2:0] A_CMD   = 3'd6;
endpackage

// File: rtl/ptm_sync.sv
module ptm_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ptm_match.sv
module ptm_match
  import ptm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample_i,
  input  logic [W-1:0] inv_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] kind_i,
  input  logic [W-1:0] sense_i,
  input  match_mode_e  mode_i,
  output logic [W-1:0] data_o,
  output logic         hit_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [W-1:0] data, prev_q, cond, edge_bits;
  logic         any_hit, all_hit, multi_edge;

  assign data = sample_i ^ inv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= data;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic rise, fall, edge_ok, lvl_ok;
      assign rise    = data[i] & ~prev_q[i];
      assign fall    = ~data[i] & prev_q[i];
      assign edge_ok = sense_i[i] ? rise : fall;
      assign lvl_ok  = sense_i[i] ? data[i] : ~data[i];
      assign cond[i] = kind_i[i] ? edge_ok : lvl_ok;
    end
  endgenerate

  assign edge_bits  = sel_i & kind_i;
  assign multi_edge = |(edge_bits & (edge_bits - 1'b1));
  assign any_hit    = |(cond & sel_i);
  assign all_hit    = (|sel_i) && (&(cond | ~sel_i)) && !multi_edge;

  always_comb begin
    case (mode_i)
      MODE_ANY: hit_o = any_hit;
      MODE_ALL: hit_o = all_hit;
      default:  hit_o = 1'b0;
    endcase
  end

  assign data_o = data;

  // R6
  and_multi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_ALL && $countones(sel_i & kind_i) > 1) |-> !hit_o);
endmodule

// File: rtl/ptm_irq.sv
module ptm_irq
  import ptm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic en_i,
  input  logic cmd_we_i,
  input  cmd_e cmd_i,
  input  logic ack_i,
  output logic ie_o,
  output logic ip_o,
  output logic ius_o,
  output logic irq_o
);
  timeunit 1ns; timeprecision 1ps;

  logic ie_q, ip_q, ius_q;
  logic clr_pnd, set_ie, clr_ie, set_ip, ack_ok;

  assign clr_pnd = cmd_we_i && cmd_i == CMD_CLR_PND;
  assign set_ie  = cmd_we_i && cmd_i == CMD_SET_IE;
  assign clr_ie  = cmd_we_i && cmd_i == CMD_CLR_IE;
  assign set_ip  = hit_i && ie_q && en_i;
  assign ack_ok  = ack_i && ie_q && ip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      ip_q  <= 1'b0;
      ius_q <= 1'b0;
    end else begin
      if (set_ie)      ie_q <= 1'b1;
      else if (clr_ie) ie_q <= 1'b0;
      ip_q <= (ip_q && !clr_pnd) || set_ip;
      if (clr_pnd)     ius_q <= 1'b0;
      else if (ack_ok) ius_q <= 1'b1;
    end
  end

  assign ie_o  = ie_q;
  assign ip_o  = ip_q;
  assign ius_o = ius_q;
  assign irq_o = ie_q && ip_q && !ius_q;

  // R10
  ius_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ius_q) |-> $past(ack_i && ie_q && ip_q));
  // R8
  ip_set_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ip_q) |-> $past(hit_i && ie_q && en_i));
  // R9
  clr_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_i == CMD_CLR_IE) |=> !ie_q);
  // R11
  ip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_q && !(cmd_we_i && cmd_i == CMD_CLR_PND)) |=> ip_q);
endmodule

// File: rtl/ptm_regs.sv
module ptm_regs
  import ptm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] data_i,
  input  logic         ie_i,
  input  logic         ip_i,
  input  logic         ius_i,
  output logic [W-1:0] sel_o,
  output logic [W-1:0] kind_o,
  output logic [W-1:0] sense_o,
  output logic [W-1:0] inv_o,
  output match_mode_e  mode_o,
  output logic         en_o,
  output logic         cmd_we_o,
  output cmd_e         cmd_o,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);
  timeunit 1ns; timeprecision 1ps;

  localparam int UB = 4;

  logic [W-1:0]  sel_q, kind_q, sense_q, inv_q, rd_q, rd_mux;
  logic [1:0]    mode_q;
  logic          en_q, rv_q;
  logic [UB-1:0] user_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      kind_q  <= '0;
      sense_q <= '0;
      inv_q   <= '0;
      mode_q  <= '0;
      en_q    <= 1'b0;
      user_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_SEL:   sel_q   <= wr_data;
        A_KIND:  kind_q  <= wr_data;
        A_SENSE: sense_q <= wr_data;
        A_INV:   inv_q   <= wr_data;
        A_MODE: begin
          mode_q <= wr_data[1:0];
          en_q   <= wr_data[4];
        end
        A_CMD:   user_q  <= wr_data[UB-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_PINS:  rd_mux = data_i;
      A_SEL:   rd_mux = sel_q;
      A_KIND:  rd_mux = kind_q;
      A_SENSE: rd_mux = sense_q;
      A_INV:   rd_mux = inv_q;
      A_MODE: begin
        rd_mux[1:0] = mode_q;
        rd_mux[4]   = en_q;
      end
      A_CMD: begin
        rd_mux[UB-1:0] = user_q;
        rd_mux[5]      = ip_i;
        rd_mux[6]      = ie_i;
        rd_mux[7]      = ius_i;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= rd_en;
      if (rd_en) rd_q <= rd_mux;
    end
  end

  assign sel_o    = sel_q;
  assign kind_o   = kind_q;
  assign sense_o  = sense_q;
  assign inv_o    = inv_q;
  assign mode_o   = match_mode_e'(mode_q);
  assign en_o     = en_q;
  assign cmd_we_o = wr_en && addr == A_CMD;
  assign cmd_o    = cmd_e'(wr_data[6:4]);
  assign rd_data  = rd_q;
  assign rd_valid = rv_q;

  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/pattern_irq_port.sv
module pattern_irq_port
  import ptm_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  input  logic         ack_i,
  output logic         irq_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [W-1:0] sample, data, sel, kind, sense, inv;
  match_mode_e  mode;
  cmd_e         cmd;
  logic         en, cmd_we, hit, ie, ip, ius;

  ptm_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(sample)
  );

  ptm_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .inv_i(inv),
    .sel_i(sel), .kind_i(kind), .sense_i(sense), .mode_i(mode),
    .data_o(data), .hit_o(hit)
  );

  ptm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .en_i(en),
    .cmd_we_i(cmd_we), .cmd_i(cmd), .ack_i(ack_i),
    .ie_o(ie), .ip_o(ip), .ius_o(ius), .irq_o(irq_o)
  );

  ptm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .data_i(data), .ie_i(ie), .ip_i(ip), .ius_i(ius),
    .sel_o(sel), .kind_o(kind), .sense_o(sense), .inv_o(inv),
    .mode_o(mode), .en_o(en), .cmd_we_o(cmd_we), .cmd_o(cmd),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/pattern_irq_port_test.sv
module pattern_irq_port_test;
  timeunit 1ns; timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins_i = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ack_i = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid, irq_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  pattern_irq_port uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .ack_i(ack_i), .irq_o(irq_o)
  );

  // monitor: pops expected read results as they appear
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: got %02h expected none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: got %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic irq_is(input logic e, input string t);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq got %0b expected %0b", t, irq_o, e);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk); pins_i = p; settle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    irq_is(1'b0, "R1 irq after reset");
    for (int a = 0; a < 7; a++) rd(3'(a), 8'h00, "R1 reset register");
    // R9 set IE with user bits 5
    wr(3'd6, 8'h25);
    rd(3'd6, 8'h45, "R9 set IE keeps user bits");
    // R3 rising edge on bit0, any-bit mode, port enabled
    wr(3'd1, 8'h01); wr(3'd2, 8'h01); wr(3'd3, 8'h01); wr(3'd5, 8'h11);
    rd(3'd5, 8'h11, "R1 mode register layout");
    settle();
    rd(3'd6, 8'h45, "R3 no edge yet");
    set_pins(8'h01);
    irq_is(1'b1, "R3 rising edge");
    rd(3'd6, 8'h65, "R3 pending set");
    wr(3'd6, 8'h15);
    settle();
    rd(3'd6, 8'h45, "R3 edge sets pending once");
    irq_is(1'b0, "R9 clear pending drops irq");
    set_pins(8'h00);
    rd(3'd6, 8'h45, "R3 falling ignored with sense=1");
    // R12 latency
    @(negedge clk); pins_i = 8'h01;
    @(negedge clk); irq_is(1'b0, "R12 edge+1");
    @(negedge clk); irq_is(1'b0, "R12 edge+2");
    @(negedge clk); irq_is(1'b1, "R12 edge+3");
    wr(3'd6, 8'h15);
    // R3 falling edge
    wr(3'd3, 8'h00);
    settle(); wr(3'd6, 8'h15);
    rd(3'd6, 8'h45, "R3 idle before falling");
    set_pins(8'h00);
    rd(3'd6, 8'h65, "R3 falling edge");
    wr(3'd6, 8'h15);
    // R2 unselected bits
    set_pins(8'hFE);
    set_pins(8'h00);
    rd(3'd6, 8'h45, "R2 unselected bits ignored");
    // R4 level high on bit1
    wr(3'd1, 8'h02); wr(3'd2, 8'h00); wr(3'd3, 8'h02);
    settle(); wr(3'd6, 8'h15);
    rd(3'd6, 8'h45, "R4 low does not match high");
    set_pins(8'h02);
    irq_is(1'b1, "R4 high level");
    // R11 level holds
    wr(3'd6, 8'h15); settle();
    rd(3'd6, 8'h65, "R11 level re-sets pending");
    set_pins(8'h00); wr(3'd6, 8'h15);
    rd(3'd6, 8'h45, "R11 cleared after release");
    wr(3'd3, 8'h00); settle();
    rd(3'd6, 8'h65, "R4 low level");
    wr(3'd3, 8'h02); settle(); wr(3'd6, 8'h15);
    // R5 any-bit with two selected bits
    wr(3'd1, 8'h0C); wr(3'd3, 8'h0C);
    set_pins(8'h04);
    rd(3'd6, 8'h65, "R5 bit2 alone");
    set_pins(8'h00); wr(3'd6, 8'h15);
    set_pins(8'h08);
    rd(3'd6, 8'h65, "R5 bit3 alone");
    set_pins(8'h00); wr(3'd6, 8'h15);
    // R6 all-bits
    wr(3'd5, 8'h12);
    set_pins(8'h04);
    rd(3'd6, 8'h45, "R6 partial pattern");
    set_pins(8'h0C);
    rd(3'd6, 8'h65, "R6 full pattern");
    set_pins(8'h00); wr(3'd6, 8'h15);
    wr(3'd2, 8'h04);
    set_pins(8'h08);
    rd(3'd6, 8'h45, "R6 level without edge");
    set_pins(8'h0C);
    rd(3'd6, 8'h65, "R6 edge plus level");
    set_pins(8'h00); wr(3'd6, 8'h15);
    wr(3'd2, 8'h0C);
    set_pins(8'h0C);
    rd(3'd6, 8'h45, "R6 two edge bits rejected");
    set_pins(8'h00); wr(3'd6, 8'h15);
    // R7 inversion
    wr(3'd5, 8'h11); wr(3'd2, 8'h00); wr(3'd1, 8'h80); wr(3'd3, 8'h80);
    wr(3'd4, 8'h80);
    settle();
    rd(3'd0, 8'h80, "R7 inverted pin read");
    rd(3'd6, 8'h65, "R7 inverted low matches high");
    set_pins(8'h80); wr(3'd6, 8'h15); settle();
    rd(3'd6, 8'h45, "R7 inverted high no match");
    rd(3'd0, 8'h00, "R7 pin read after inversion");
    wr(3'd4, 8'h00); set_pins(8'h00); wr(3'd6, 8'h15);
    // R8 qualification
    wr(3'd6, 8'h35);
    wr(3'd1, 8'h01); wr(3'd3, 8'h01);
    set_pins(8'h01);
    rd(3'd6, 8'h05, "R8 no pending with IE off");
    irq_is(1'b0, "R8 irq with IE off");
    wr(3'd6, 8'h25); settle();
    rd(3'd6, 8'h65, "R8 pending after IE set");
    wr(3'd5, 8'h01); wr(3'd6, 8'h15); settle();
    rd(3'd6, 8'h45, "R8 port disabled");
    wr(3'd5, 8'h13); settle();
    rd(3'd6, 8'h45, "R8 mode 11 off");
    // R10 acknowledge
    wr(3'd5, 8'h11); settle();
    set_pins(8'h00);
    irq_is(1'b1, "R10 irq before ack");
    @(negedge clk); ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
    irq_is(1'b0, "R10 irq under service");
    rd(3'd6, 8'hE5, "R10 ack sets IUS");
    wr(3'd6, 8'h1A);
    rd(3'd6, 8'h4A, "R9 clear IP IUS stores user");
    @(negedge clk); ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
    rd(3'd6, 8'h4A, "R10 ack without IP ignored");
    irq_is(1'b0, "R10 irq stays low");
    settle();
    summary();
    $finish;
  end
endmodule